// File: doc/BRIEF.md
# Push-Pull PWM Output Steering Logic

This block turns one single-ended PWM pulse stream into two gate-drive enables, channel A and channel B. A pulse is active only while the non-inverting input is high and the inverting input is low. Driving one input and tying off the other therefore accepts either active-high or active-low pulse sources. In alternate mode a toggle steers each new pulse to the other channel, which gives push-pull drive. In parallel mode both channels follow every pulse in phase.

Two rules guard the toggle and the stop latch against glitches and double pulses:

- A pulse counts as new only if the combined input has first stayed low for `OFF_CYCLES` clocks. A re-assertion that comes sooner belongs to the pulse before it.
- A stop request latches and holds both outputs low. The latch clears only after such a qualified off-time with the stop request low, so shutdown works pulse by pulse.

Three further controls act on the outputs. A thermal-fault flag forces both outputs low for as long as it is asserted. Each channel also has an inhibit flag, which reports that the opposite power switch is still conducting. All asynchronous inputs pass through two-flop synchronizers.

Top module: `pulse_steer`

## Requirements
- R1: The combined pulse is active only for non-inverting input 1 with inverting input 0. Any other input pair gives `driveA = driveB = 0`.
- R2: With `altMode = 1`, each qualified pulse is steered to one channel only, alternating A, B, A, ... The two outputs are never high together. The toggle advances on every qualified pulse in either mode.
- R3: With `altMode = 0`, both outputs follow the combined pulse together (unless gated by R6 to R8).
- R4: After reset both outputs are low and channel A receives the first pulse.
- R5: A pulse counts as new only when the combined input was low for at least `OFF_CYCLES` clock edges before it. A shorter gap keeps the pulse on the same channel.
- R6: `stopReq` forces both outputs low. They stay low for the rest of the pulse and through re-assertions after gaps shorter than `OFF_CYCLES`. Drive returns on the first pulse after a qualified off-time with `stopReq` low.
- R7: `thermFault` holds both outputs low while it is asserted. Drive resumes when it clears, if the pulse is still active.
- R8: A channel stays low while its inhibit flag (`inhibitA` or `inhibitB`) is 1. It turns on when the flag clears, if the pulse is still active and no stop or thermal fault holds it off.
- R9: A change at any input appears at the outputs on the third rising clock edge after it (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseNonInv | input | 1 | Non-inverting PWM pulse input |
| pulseInv | input | 1 | Inverting PWM pulse input |
| altMode | input | 1 | 1 = alternate (push-pull), 0 = parallel |
| stopReq | input | 1 | Latched stop request |
| thermFault | input | 1 | Over-temperature flag |
| inhibitA | input | 1 | Opposite switch still on; blocks channel A |
| inhibitB | input | 1 | Opposite switch still on; blocks channel B |
| driveA | output | 1 | Channel A drive enable |
| driveB | output | 1 | Channel B drive enable |

## Verification
The hardest condition to reach from the ports is the exact off-time boundary. A gap of `OFF_CYCLES - 1` must leave the toggle and the stop latch untouched, while a gap of exactly `OFF_CYCLES` must advance the toggle and clear the latch. The bench produces double pulses whose gaps sweep across that boundary one clock at a time. It predicts the channel of each pulse from its own count of qualified pulses. It also sweeps every combination of the two pulse inputs, mode, thermal flag and inhibit flags, with an idle spacing long enough that each pulse qualifies.

// File: rtl/pulse_steer_pkg.sv
package pulse_steer_pkg;

  // Bit order of the raw input bundle fed to the synchronizer.
  localparam int NUM_ASYNC = 7;

  typedef struct packed {
    logic nonInv;
    logic inv;
    logic alt;
    logic stop;
    logic therm;
    logic inhA;
    logic inhB;
  } asyncIn_t;

  // Status from datapath to control.
  typedef struct packed {
    logic pulseOn;    // combined pulse active now
    logic pulseRise;  // first cycle of an active pulse
    logic offQual;    // off-time has reached OFF_CYCLES
  } pulseStat_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic gateA;
    logic gateB;
  } gate_t;

endpackage

// File: rtl/pulse_steer_sync.sv
module pulse_steer_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pulse_steer_datapath.sv
module pulse_steer_datapath
  import pulse_steer_pkg::*;
#(
  parameter int OFF_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nonInvS,
  input  logic       invS,
  input  gate_t      gates,
  output pulseStat_t stat,
  output logic       driveA,
  output logic       driveB
);

  localparam int CNT_W = $clog2(OFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] OFF_MAX = CNT_W'(OFF_CYCLES);

  logic             pulseOn;
  logic             pulseDly;
  logic [CNT_W-1:0] offCnt;

  assign pulseOn = nonInvS & ~invS;

  // Off-time counter: cleared while the pulse is on, saturates at OFF_MAX.
  // Reset value is saturated so the first pulse after reset is a new one.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt   <= OFF_MAX;
      pulseDly <= 1'b0;
    end else begin
      pulseDly <= pulseOn;
      if (pulseOn) begin
        offCnt <= '0;
      end else if (offCnt != OFF_MAX) begin
        offCnt <= offCnt + 1'b1;
      end
    end
  end

  assign stat.pulseOn   = pulseOn;
  assign stat.pulseRise = pulseOn & ~pulseDly;
  assign stat.offQual   = (offCnt == OFF_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveA <= 1'b0;
      driveB <= 1'b0;
    end else begin
      driveA <= pulseOn & gates.gateA;
      driveB <= pulseOn & gates.gateB;
    end
  end

endmodule

// File: rtl/pulse_steer_control.sv
module pulse_steer_control
  import pulse_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pulseStat_t stat,
  input  logic       altS,
  input  logic       stopS,
  input  logic       thermS,
  input  logic       inhAS,
  input  logic       inhBS,
  output gate_t      gates
);

  logic newPulse;
  logic nextB;
  logic curB;
  logic selB;
  logic stopLatch;
  logic blockAll;

  assign newPulse = stat.pulseRise & stat.offQual;
  assign selB     = newPulse ? nextB : curB;

  // Toggle: a new pulse takes the pending channel and flips it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextB <= 1'b0;
      curB  <= 1'b0;
    end else if (newPulse) begin
      curB  <= nextB;
      nextB <= ~nextB;
    end
  end

  // Stop latch: set has priority, clears after a qualified off-time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopLatch <= 1'b0;
    end else if (stopS) begin
      stopLatch <= 1'b1;
    end else if (stat.offQual) begin
      stopLatch <= 1'b0;
    end
  end

  assign blockAll    = stopLatch | stopS | thermS;
  assign gates.gateA = ~blockAll & ~inhAS & (~altS | ~selB);
  assign gates.gateB = ~blockAll & ~inhBS & (~altS | selB);

endmodule

// File: rtl/pulse_steer.sv
module pulse_steer
  import pulse_steer_pkg::*;
#(
  parameter int OFF_CYCLES  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseNonInv,
  input  logic pulseInv,
  input  logic altMode,
  input  logic stopReq,
  input  logic thermFault,
  input  logic inhibitA,
  input  logic inhibitB,
  output logic driveA,
  output logic driveB
);

  asyncIn_t   rawIn;
  asyncIn_t   syncIn;
  pulseStat_t stat;
  gate_t      gates;

  logic altS, stopS, thermS, inhAS, inhBS, pulseOnS;

  assign rawIn = '{nonInv: pulseNonInv, inv: pulseInv, alt: altMode,
                   stop: stopReq, therm: thermFault,
                   inhA: inhibitA, inhB: inhibitB};

  pulse_steer_sync #(
    .WIDTH  (NUM_ASYNC),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign altS     = syncIn.alt;
  assign stopS    = syncIn.stop;
  assign thermS   = syncIn.therm;
  assign inhAS    = syncIn.inhA;
  assign inhBS    = syncIn.inhB;
  assign pulseOnS = stat.pulseOn;

  pulse_steer_datapath #(
    .OFF_CYCLES (OFF_CYCLES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .nonInvS (syncIn.nonInv),
    .invS    (syncIn.inv),
    .gates   (gates),
    .stat    (stat),
    .driveA  (driveA),
    .driveB  (driveB)
  );

  pulse_steer_control ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .altS   (altS),
    .stopS  (stopS),
    .thermS (thermS),
    .inhAS  (inhAS),
    .inhBS  (inhBS),
    .gates  (gates)
  );

endmodule

// File: rtl/pulse_steer_chk.sv
module pulse_steer_chk (
  input logic clk,
  input logic rstN,
  input logic driveA,
  input logic driveB,
  input logic altS,
  input logic stopS,
  input logic thermS,
  input logic inhAS,
  input logic inhBS,
  input logic pulseOnS
);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pulseOnS) |-> (!driveA && !driveB));

  // R2
  alt_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(altS) |-> !(driveA && driveB));

  // R3
  par_in_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!altS && !inhAS && !inhBS) |-> (driveA == driveB));

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopS) |-> (!driveA && !driveB));

  // R7
  therm_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(thermS) |-> (!driveA && !driveB));

  // R8
  inhibit_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inhAS) |-> !driveA);

  // R8
  inhibit_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inhBS) |-> !driveB);

endmodule

bind pulse_steer pulse_steer_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .driveA   (driveA),
  .driveB   (driveB),
  .altS     (altS),
  .stopS    (stopS),
  .thermS   (thermS),
  .inhAS    (inhAS),
  .inhBS    (inhBS),
  .pulseOnS (pulseOnS)
);

// File: tb/pulse_steer_tb_top.sv
module pulse_steer_tb_top;

  localparam int OFF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ni = 0, iv = 0, alt = 0, st = 0, th = 0, ia = 0, ib = 0;
  logic driveA, driveB;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;
  // Bench model of the toggle.
  bit  nextB   = 0;
  bit  curB    = 0;

  always #5 clk = ~clk;

  pulse_steer #(.OFF_CYCLES(OFF)) dut_i (
    .clk(clk), .rstN(rstN), .pulseNonInv(ni), .pulseInv(iv),
    .altMode(alt), .stopReq(st), .thermFault(th),
    .inhibitA(ia), .inhibitB(ib), .driveA(driveA), .driveB(driveB)
  );

  task automatic chk(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic newPulse();
    curB  = nextB;
    nextB = ~nextB;
  endtask

  task automatic idle();
    ni = 0; iv = 0; th = 0; ia = 0; ib = 0; st = 0;
    hold(OFF + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    hold(3);
    rstN = 1'b1;
    hold(2);
    // R4 reset state
    chk("R4 reset A", driveA, 1'b0);
    chk("R4 reset B", driveB, 1'b0);

    // R9 latency and R4 first pulse on A
    alt = 1;
    hold(OFF + 4);
    ni = 1;
    hold(2);
    chk("R9 two edges A", driveA, 1'b0);
    hold(1);
    newPulse();
    chk("R9 third edge A", driveA, 1'b1);
    chk("R4 first pulse on A", curB, 1'b0);
    chk("R2 first pulse B off", driveB, 1'b0);
    idle();

    // R1 R2 R3 R7 R8 sweep over inputs and mode
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 32; c++) begin
        logic drv, eA, eB;
        alt = logic'(m);
        hold(OFF + 4);
        ni = c[0]; iv = c[1]; th = c[2]; ia = c[3]; ib = c[4];
        drv = c[0] & ~c[1];
        if (drv) newPulse();
        hold(4);
        eA = drv & ~th & ~ia & (~alt | ~curB);
        eB = drv & ~th & ~ib & (~alt | curB);
        chk(alt ? "R2/R1/R7/R8 alt A" : "R3/R1/R7/R8 par A", driveA, eA);
        chk(alt ? "R2/R1/R7/R8 alt B" : "R3/R1/R7/R8 par B", driveB, eB);
        idle();
        chk("R1 idle A", driveA, 1'b0);
        chk("R1 idle B", driveB, 1'b0);
      end
    end

    // R5 gap sweep across the off-time boundary
    alt = 1;
    for (int g = OFF - 2; g <= OFF + 1; g++) begin
      ni = 1;
      newPulse();
      hold(6);
      ni = 0;
      hold(g);
      ni = 1;
      if (g >= OFF) newPulse();
      hold(4);
      chk("R5 gap channel A", driveA, ~curB);
      chk("R5 gap channel B", driveB, curB);
      idle();
    end

    // R6 stop latch, pulse by pulse
    alt = 0;
    hold(4);
    ni = 1;
    newPulse();
    hold(4);
    chk("R6 before stop", driveA, 1'b1);
    st = 1;
    hold(1);
    st = 0;
    hold(4);
    chk("R6 stop latched A", driveA, 1'b0);
    chk("R6 stop latched B", driveB, 1'b0);
    ni = 0;
    hold(3);
    ni = 1;
    hold(4);
    chk("R6 short gap still off", driveA, 1'b0);
    ni = 0;
    hold(OFF + 2);
    ni = 1;
    newPulse();
    hold(4);
    chk("R6 cleared after off-time A", driveA, 1'b1);
    chk("R6 cleared after off-time B", driveB, 1'b1);
    idle();

    // R7 thermal release mid-pulse
    ni = 1;
    newPulse();
    hold(4);
    th = 1;
    hold(4);
    chk("R7 thermal holds low", driveA, 1'b0);
    th = 0;
    hold(4);
    chk("R7 thermal release", driveA, 1'b1);
    idle();

    // R8 inhibit release mid-pulse
    ia = 1;
    ni = 1;
    newPulse();
    hold(4);
    chk("R8 inhibited A", driveA, 1'b0);
    chk("R8 uninhibited B", driveB, 1'b1);
    ia = 0;
    hold(4);
    chk("R8 release A", driveA, 1'b1);
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule